// File: doc/BRIEF.md
# MSI Write Page Receiver

This block is a memory-mapped target on a simple 32-bit valid/ready register bus. Devices send message-signaled interrupts as plain word writes into a window. The window is split into 4 KiB pages, one page for each interrupt file. The block splits every address into a page number (address shifted right by 12) and an offset inside the page. It throws away accesses that are not word-sized, not word-aligned, or outside the window. A well-formed write to the set-pending slot at the start of a page becomes a one-cycle set-pending request that carries the page number and the interrupt identity. That identity is the data word.

The window spans `NUM_PAGES` pages starting at offset zero, and the base address must be page-aligned. Identities run from 1 to `NUM_IDS-1`. Identity zero and larger values are dropped without comment. Reads are accepted and always return zero. Pending storage and priority selection sit downstream and consume the strobe.

Top module: `msi_page_receiver`

## Requirements
- R1: `req_ready` is always high. Each handshake is answered by `rsp_valid` high for exactly the cycle after it, with `rsp_rdata` equal to zero.
- R2: An access is dropped and `err_pulse` is high for the cycle after the handshake, with no strobe, in either of two cases: `req_size` is not 2 (the code for a 4-byte word), or `req_addr[1:0]` is nonzero.
- R3: An access at or beyond `NUM_PAGES*4096` is dropped and raises `err_pulse` the following cycle, with no strobe. The last word below that limit is in range.
- R4: The strobe's `sp_page` equals `req_addr >> 12`, and the in-page offset is `req_addr[11:0]`.
- R5: A write at in-page offset 0x000 whose data d satisfies 1 <= d < `NUM_IDS` drives `sp_valid` high for the cycle after the handshake. In that cycle it presents the page and `sp_id` = d.
- R6: Writes at any other in-range aligned offset are ignored without an error. This includes 0x004, the big-endian slot.
- R7: A set-pending write whose full 32-bit data is zero or at least `NUM_IDS` produces neither a strobe nor an error.
- R8: Aligned in-range word reads produce neither a strobe nor an error. Misaligned reads raise `err_pulse`.
- R9: While `rst` is high, and in the cycle after it, all outputs except `req_ready` are zero.
- R10: Accepted writes on consecutive cycles produce strobes on consecutive cycles, each with its own page and identity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the window |
| req_size | input | 2 | log2 of access bytes; 2 = word |
| req_wdata | input | 32 | Write data (identity) |
| rsp_valid | output | 1 | Response, one cycle after handshake |
| rsp_rdata | output | 32 | Read data, always zero |
| sp_valid | output | 1 | Set-pending strobe |
| sp_page | output | PAGE_W | Page of the strobe |
| sp_id | output | ID_W | Identity to mark pending |
| err_pulse | output | 1 | Malformed access seen |

## Verification
The response to a handshake lands in the same cycle as the result of that handshake: the set-pending strobe, the error pulse, or neither. The bench sends one stream of back-to-back requests that mixes accepted, dropped and malformed accesses, reads and writes. At one sampling point it judges `rsp_valid` together with the strobe fields and `err_pulse` against the vector's expectation. Consecutive accepted writes also check that one request's strobe does not leak into its neighbour's cycle.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;

    localparam int unsigned PAGE_SHIFT   = 12;
    localparam logic [1:0]  SIZE_WORD    = 2'd2;

    typedef enum logic [1:0] {
        ACC_NOP     = 2'd0,
        ACC_SETPEND = 2'd1,
        ACC_REJECT  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic misaligned;
        logic out_of_range;
        logic le_slot;
    } addr_class_t;

    function automatic int unsigned width_of(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
    import msi_rx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned NUM_PAGES = 4,
    parameter int unsigned PAGE_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output addr_class_t       cls,
    output logic [PAGE_W-1:0] page
);
    localparam logic [ADDR_W:0] WINDOW_END =
        (ADDR_W+1)'(NUM_PAGES * (1 << PAGE_SHIFT));

    logic [ADDR_W-1:0] page_full;

    always_comb begin
        cls.misaligned   = (size != SIZE_WORD) || (addr[1:0] != 2'b00);
        cls.out_of_range = ({1'b0, addr} >= WINDOW_END);
        cls.le_slot      = (addr[PAGE_SHIFT-1:0] == '0);
        page_full        = addr >> PAGE_SHIFT;
        page             = page_full[PAGE_W-1:0];
    end
endmodule

// File: rtl/msi_id_filter.sv
module msi_id_filter #(
    parameter int unsigned NUM_IDS = 64,
    parameter int unsigned ID_W    = 6
) (
    input  logic [31:0]     data,
    output logic            id_ok,
    output logic [ID_W-1:0] id
);
    localparam logic [31:0] ID_LIMIT = 32'(NUM_IDS);

    always_comb begin
        id_ok = (data != 32'd0) && (data < ID_LIMIT);
        id    = data[ID_W-1:0];
    end
endmodule

// File: rtl/msi_req_classify.sv
module msi_req_classify
    import msi_rx_pkg::*;
(
    input  logic        is_write,
    input  addr_class_t cls,
    input  logic        id_ok,
    output acc_kind_e   kind
);
    always_comb begin
        if (cls.misaligned || cls.out_of_range)
            kind = ACC_REJECT;
        else if (is_write && cls.le_slot && id_ok)
            kind = ACC_SETPEND;
        else
            kind = ACC_NOP;
    end
endmodule

// File: rtl/msi_page_receiver.sv
module msi_page_receiver
    import msi_rx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned NUM_PAGES = 4,
    parameter int unsigned NUM_IDS   = 64,
    localparam int unsigned PAGE_W   = width_of(NUM_PAGES),
    localparam int unsigned ID_W     = width_of(NUM_IDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              sp_valid,
    output logic [PAGE_W-1:0] sp_page,
    output logic [ID_W-1:0]   sp_id,
    output logic              err_pulse
);
    addr_class_t       cls;
    logic [PAGE_W-1:0] dec_page;
    logic              id_ok;
    logic [ID_W-1:0]   dec_id;
    acc_kind_e         kind;
    logic              hs;

    msi_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)
    ) u_decode (
        .addr(req_addr), .size(req_size), .cls(cls), .page(dec_page)
    );

    msi_id_filter #(
        .NUM_IDS(NUM_IDS), .ID_W(ID_W)
    ) u_filter (
        .data(req_wdata), .id_ok(id_ok), .id(dec_id)
    );

    msi_req_classify u_classify (
        .is_write(req_write), .cls(cls), .id_ok(id_ok), .kind(kind)
    );

    assign req_ready = 1'b1;
    assign hs        = req_valid && req_ready;
    assign rsp_rdata = 32'd0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            sp_valid  <= 1'b0;
            err_pulse <= 1'b0;
            sp_page   <= '0;
            sp_id     <= '0;
        end else begin
            rsp_valid <= hs;
            sp_valid  <= hs && (kind == ACC_SETPEND);
            err_pulse <= hs && (kind == ACC_REJECT);
            if (hs && (kind == ACC_SETPEND)) begin
                sp_page <= dec_page;
                sp_id   <= dec_id;
            end
        end
    end

    a_r1_response: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    a_r5_strobe_from_write: assert property (@(posedge clk) disable iff (rst)
        sp_valid |-> $past(req_valid && req_write && req_size == SIZE_WORD));

    a_r7_id_in_range: assert property (@(posedge clk) disable iff (rst)
        sp_valid |-> (sp_id != '0) && (32'(sp_id) < 32'(NUM_IDS)));

    a_r3_page_in_range: assert property (@(posedge clk) disable iff (rst)
        sp_valid |-> (32'(sp_page) < 32'(NUM_PAGES)));

    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sp_valid && err_pulse));

    a_r2_err_from_req: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(req_valid));
endmodule

// File: tb/test_msi_page_receiver.sv
module test_msi_page_receiver;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [15:0] req_addr;
    logic [1:0]  req_size;
    logic [31:0] req_wdata;
    logic        req_ready, rsp_valid, sp_valid, err_pulse;
    logic [31:0] rsp_rdata;
    logic [1:0]  sp_page;
    logic [5:0]  sp_id;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    msi_page_receiver #(.ADDR_W(16), .NUM_PAGES(4), .NUM_IDS(64)) i_msi_page_receiver (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sp_valid(sp_valid), .sp_page(sp_page), .sp_id(sp_id), .err_pulse(err_pulse)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic        sp;
        logic [1:0]  pg;
        logic [5:0]  id;
        logic        err;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h0000, 2'd2, 32'd5,          1'b1, 2'd0, 6'd5,  1'b0}, // R5
        '{1'b1, 16'h3000, 2'd2, 32'd63,         1'b1, 2'd3, 6'd63, 1'b0}, // R4 R5
        '{1'b1, 16'h1000, 2'd2, 32'd64,         1'b0, 2'd0, 6'd0,  1'b0}, // R7
        '{1'b1, 16'h2000, 2'd2, 32'd0,          1'b0, 2'd0, 6'd0,  1'b0}, // R7
        '{1'b1, 16'h2004, 2'd2, 32'd7,          1'b0, 2'd0, 6'd0,  1'b0}, // R6
        '{1'b1, 16'h2010, 2'd2, 32'd7,          1'b0, 2'd0, 6'd0,  1'b0}, // R6
        '{1'b1, 16'h1002, 2'd2, 32'd7,          1'b0, 2'd0, 6'd0,  1'b1}, // R2
        '{1'b1, 16'h1000, 2'd1, 32'd7,          1'b0, 2'd0, 6'd0,  1'b1}, // R2
        '{1'b1, 16'h4000, 2'd2, 32'd7,          1'b0, 2'd0, 6'd0,  1'b1}, // R3
        '{1'b1, 16'hFFFC, 2'd2, 32'd9,          1'b0, 2'd0, 6'd0,  1'b1}, // R3
        '{1'b0, 16'h1000, 2'd2, 32'd0,          1'b0, 2'd0, 6'd0,  1'b0}, // R8
        '{1'b0, 16'h1001, 2'd2, 32'd0,          1'b0, 2'd0, 6'd0,  1'b1}, // R8
        '{1'b1, 16'h2000, 2'd2, 32'h8000_0003,  1'b0, 2'd0, 6'd0,  1'b0}, // R7
        '{1'b1, 16'h2000, 2'd2, 32'd1,          1'b1, 2'd2, 6'd1,  1'b0}, // R5 R10
        '{1'b1, 16'h3FFC, 2'd2, 32'd1,          1'b0, 2'd0, 6'd0,  1'b0}, // R3 R6
        '{1'b1, 16'h1000, 2'd2, 32'd42,         1'b1, 2'd1, 6'd42, 1'b0}  // R10
    };

    task automatic chk(input string tag, input int idx, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s item %0d actual %0h expected %0h", tag, idx, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic wr, input logic [15:0] a,
                         input logic [1:0] s, input logic [31:0] d);
        req_valid = v; req_write = wr; req_addr = a; req_size = s; req_wdata = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 16'h0, 2'd2, 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9 rsp_valid", 0, 32'(rsp_valid), 0);
        chk("R9 sp_valid", 0, 32'(sp_valid), 0);
        chk("R9 err_pulse", 0, 32'(err_pulse), 0);
        chk("R1 req_ready", 0, 32'(req_ready), 1);
        // R9: a request during reset has no effect
        drive(1'b1, 1'b1, 16'h0000, 2'd2, 32'd9);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b0, 16'h0, 2'd2, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R9 sp after reset", 0, 32'(sp_valid), 0);
        chk("R9 rsp after reset", 0, 32'(rsp_valid), 0);

        // back-to-back vector stream: R1..R8, R10
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i].wr, VEC[i].addr, VEC[i].size, VEC[i].data);
            @(posedge clk);
            @(negedge clk);
            chk("R1 rsp_valid", i, 32'(rsp_valid), 1);
            chk("R1 rsp_rdata", i, rsp_rdata, 0);
            chk("R5 sp_valid", i, 32'(sp_valid), 32'(VEC[i].sp));
            chk("R2 err_pulse", i, 32'(err_pulse), 32'(VEC[i].err));
            if (VEC[i].sp) begin
                chk("R4 sp_page", i, 32'(sp_page), 32'(VEC[i].pg));
                chk("R5 sp_id", i, 32'(sp_id), 32'(VEC[i].id));
            end
        end

        // R1: one-cycle pulses end when the bus goes idle
        drive(1'b0, 1'b0, 16'h0, 2'd2, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R1 rsp idle", 100, 32'(rsp_valid), 0);
        chk("R5 sp idle", 100, 32'(sp_valid), 0);

        // R10: isolated write after idle, then idle again
        drive(1'b1, 1'b1, 16'h3000, 2'd2, 32'd17);
        @(posedge clk);
        @(negedge clk);
        drive(1'b0, 1'b0, 16'h0, 2'd2, 32'd0);
        chk("R10 sp_valid", 101, 32'(sp_valid), 1);
        chk("R4 sp_page", 101, 32'(sp_page), 3);
        chk("R5 sp_id", 101, 32'(sp_id), 17);
        @(posedge clk);
        @(negedge clk);
        chk("R10 single pulse", 102, 32'(sp_valid), 0);
        chk("R2 err idle", 102, 32'(err_pulse), 0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule